// File: doc/BRIEF.md
# Checkpoint Register Recovery Sequencer

This block drives hardware error recovery for a processor whose committed state lives in a checkpoint register array, with every register kept as a single-error-correcting, double-error-detecting codeword. In normal operation it watches two duplicated execution results and a general error-detected line. When either one fires, it takes the machine through a fixed recovery. First it freezes the checkpoint so no pending instruction can update it. It then asks the store path to push out stores that are already checkpointed, and only after that strobes a reset of the cache arrays and branch target buffer. Next it walks every checkpoint register in ascending order, corrects each value and writes the clean codeword back to the array and the data to the shadow copies. A second read pass confirms the array is clean. Finally it raises a restart interrupt and a log request together.

Some failures leave the machine unusable, and the block then enters a permanent check-stop state. These are: an uncorrectable word during the correction pass, any error seen in the confirming pass, a handshake that does not complete in time, and a new error in the window between restart and the first completed instruction. Reset is the only way out of check-stop.

Top module: `ckpt_recovery_seq`

## Requirements
- R1: After reset, busy, check_stop, ckpt_freeze, drain_req, arr_reset, rf_we, sh_we, restart_irq and log_irq are all 0.
- R2: While idle, a cycle with dup_valid=1 and dup_res_a different from dup_res_b, or a cycle with err_det=1, makes busy and ckpt_freeze 1 in the next cycle. Unequal results with dup_valid=0, and equal results with dup_valid=1, start nothing.
- R3: One cycle after recovery starts, drain_req rises and stays high until a cycle with drain_done=1. In the next cycle arr_reset is 1 for exactly one cycle and drain_req is 0. The block then waits for arr_done.
- R4: The drain wait and the array-reset wait each accept their done input in any of their first TIMEOUT cycles, counting the first cycle of the wait as cycle 0. If done has not arrived by cycle TIMEOUT-1, check_stop is 1 in the next cycle.
- R5: The correction pass visits registers 0 to NREG-1 in ascending order, one per cycle. For each register it writes the corrected codeword to the array and the data to the shadow copy at the same address. Any single flipped codeword bit is repaired. The codeword maps bit i to Hamming position i+1 for positions 1 to 38. Check bits sit at positions 1, 2, 4, 8, 16 and 32, data bits fill the remaining positions in ascending order, and bit 38 gives even parity over the whole word.
- R6: An uncorrectable word in the correction pass gives check-stop in the next cycle. No later array write occurs, so only the registers below it are written.
- R7: After the correction pass, every register is read again. Any correctable or uncorrectable error in this pass gives check-stop, and restart_irq is never raised.
- R8: After a clean confirming pass, restart_irq and log_irq are both 1 for exactly one cycle. In that cycle ckpt_freeze is 0 and busy is still 1.
- R9: From the restart cycle until a cycle with instr_done=1, any error input as defined in R2 gives check-stop, and this holds even when instr_done is 1 in the same cycle. A cycle with instr_done=1 and no error returns the block to idle, with busy at 0.
- R10: check_stop stays 1 until reset. In check-stop, busy is 0, ckpt_freeze stays 1, and error inputs have no effect.
- R11: Error inputs that arrive during the freeze, drain, array-reset, correction or confirming steps do not restart or alter the sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dup_valid | input | 1 | Duplicated results are valid this cycle |
| dup_res_a | input | 32 | Result from the first execution copy |
| dup_res_b | input | 32 | Result from the second execution copy |
| err_det | input | 1 | Error detected elsewhere in the processor |
| instr_done | input | 1 | First instruction after restart completed |
| ckpt_freeze | output | 1 | Blocks checkpoint updates |
| busy | output | 1 | Recovery in progress |
| drain_req | output | 1 | Request to forward checkpointed stores |
| drain_done | input | 1 | Store forwarding finished |
| arr_reset | output | 1 | One-cycle cache array and branch buffer reset strobe |
| arr_done | input | 1 | Array reset finished |
| rf_addr | output | AW | Checkpoint register index |
| rf_rdata | input | 39 | Codeword read at rf_addr, same cycle |
| rf_we | output | 1 | Checkpoint array write enable |
| rf_wdata | output | 39 | Corrected codeword |
| sh_we | output | 1 | Shadow copy write enable |
| sh_addr | output | AW | Shadow register index |
| sh_wdata | output | 32 | Corrected data to shadow copies |
| restart_irq | output | 1 | Serialization restart interrupt pulse |
| log_irq | output | 1 | Error logging interrupt pulse |
| check_stop | output | 1 | Permanent check-stop |

## Verification
Two events can fall in the same cycle. In the window after restart, a new error can arrive in the same cycle as the first instruction's completion. The bench drives err_det and instr_done together and expects check_stop rather than a return to idle. In a handshake wait, the done input can arrive in the very cycle the timeout would otherwise fire. The bench delivers arr_done in wait cycle TIMEOUT-1 and expects the correction pass to start, then delivers it one cycle later and expects check-stop.

// File: rtl/ckrec_pkg.sv
package ckrec_pkg;

    localparam int DATA_W = 32;
    localparam int CODE_W = 39;
    localparam int HPOS   = 38;

    typedef enum logic [3:0] {
        S_IDLE, S_FREEZE, S_DRAIN, S_ARST, S_AWAIT,
        S_SCRUB, S_VERIFY, S_RESTART, S_WATCH, S_STOP
    } ckrec_state_e;

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              ce;
        logic              ue;
    } ckrec_dec_t;

    function automatic logic is_pow2(input int p);
        return (p & (p - 1)) == 0;
    endfunction

    function automatic logic [CODE_W-1:0] secded_enc(input logic [DATA_W-1:0] d);
        logic [CODE_W-1:0] c;
        int k;
        c = '0;
        k = 0;
        for (int p = 1; p <= HPOS; p++) begin
            if (!is_pow2(p)) begin
                c[p-1] = d[k];
                k++;
            end
        end
        for (int b = 0; b < 6; b++) begin
            logic x;
            x = 1'b0;
            for (int p = 1; p <= HPOS; p++) begin
                if (((p >> b) & 1) == 1) x = x ^ c[p-1];
            end
            c[(1 << b) - 1] = x;
        end
        c[CODE_W-1] = ^c[CODE_W-2:0];
        return c;
    endfunction

    function automatic ckrec_dec_t secded_dec(input logic [CODE_W-1:0] cw);
        ckrec_dec_t r;
        logic [CODE_W-1:0] c;
        logic [5:0] s;
        logic par;
        int k;
        c   = cw;
        s   = '0;
        par = ^cw;
        for (int p = 1; p <= HPOS; p++) begin
            if (cw[p-1]) s = s ^ 6'(p);
        end
        r.ue = (!par && s != 6'd0) || (par && int'(s) > HPOS);
        r.ce = par && !r.ue;
        if (par && s != 6'd0 && int'(s) <= HPOS) c[int'(s)-1] = ~c[int'(s)-1];
        r.data = '0;
        k = 0;
        for (int p = 1; p <= HPOS; p++) begin
            if (!is_pow2(p)) begin
                r.data[k] = c[p-1];
                k++;
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/ckrec_trigger.sv
module ckrec_trigger
    import ckrec_pkg::*;
(
    input  logic              dup_valid,
    input  logic [DATA_W-1:0] dup_res_a,
    input  logic [DATA_W-1:0] dup_res_b,
    input  logic              err_det,
    output logic              err_now
);
    logic mismatch;

    always_comb begin
        mismatch = dup_valid && (dup_res_a != dup_res_b);
        err_now  = mismatch || err_det;
    end
endmodule

// File: rtl/ckrec_step_timer.sv
module ckrec_step_timer #(
    parameter int TIMEOUT = 1024
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic expired
);
    localparam int TW = (TIMEOUT > 1) ? $clog2(TIMEOUT + 1) : 1;

    logic [TW-1:0] cnt;

    assign expired = run && (cnt == TW'(TIMEOUT - 1));

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
        end else if (!expired) begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/ckrec_walker.sv
module ckrec_walker #(
    parameter int NREG = 16,
    parameter int AW   = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          adv,
    output logic [AW-1:0] idx,
    output logic          last
);
    assign last = (idx == AW'(NREG - 1));

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            idx <= '0;
        end else if (adv) begin
            idx <= last ? '0 : idx + 1'b1;
        end
    end
endmodule

// File: rtl/ckrec_scrub_path.sv
module ckrec_scrub_path
    import ckrec_pkg::*;
(
    input  logic [CODE_W-1:0] rd_code,
    output ckrec_dec_t        dec,
    output logic [CODE_W-1:0] fixed_code
);
    always_comb begin
        dec        = secded_dec(rd_code);
        fixed_code = secded_enc(dec.data);
    end
endmodule

// File: rtl/ckpt_recovery_seq.sv
module ckpt_recovery_seq
    import ckrec_pkg::*;
#(
    parameter int NREG    = 16,
    parameter int TIMEOUT = 1024,
    localparam int AW     = (NREG > 1) ? $clog2(NREG) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              dup_valid,
    input  logic [DATA_W-1:0] dup_res_a,
    input  logic [DATA_W-1:0] dup_res_b,
    input  logic              err_det,
    input  logic              instr_done,
    output logic              ckpt_freeze,
    output logic              busy,
    output logic              drain_req,
    input  logic              drain_done,
    output logic              arr_reset,
    input  logic              arr_done,
    output logic [AW-1:0]     rf_addr,
    input  logic [CODE_W-1:0] rf_rdata,
    output logic              rf_we,
    output logic [CODE_W-1:0] rf_wdata,
    output logic              sh_we,
    output logic [AW-1:0]     sh_addr,
    output logic [DATA_W-1:0] sh_wdata,
    output logic              restart_irq,
    output logic              log_irq,
    output logic              check_stop
);

    ckrec_state_e st, nxt;
    logic         err_now;
    logic         expired;
    logic         walk_clr, walk_adv, walk_last;
    logic [AW-1:0] walk_idx;
    ckrec_dec_t   dec;
    logic [CODE_W-1:0] fixed_code;
    logic         in_scrub, in_verify, bad_word;

    ckrec_trigger u_trig (
        .dup_valid (dup_valid),
        .dup_res_a (dup_res_a),
        .dup_res_b (dup_res_b),
        .err_det   (err_det),
        .err_now   (err_now)
    );

    ckrec_step_timer #(.TIMEOUT(TIMEOUT)) u_tmr (
        .clk     (clk),
        .rst     (rst),
        .run     ((st == S_DRAIN) || (st == S_AWAIT)),
        .expired (expired)
    );

    ckrec_walker #(.NREG(NREG), .AW(AW)) u_walk (
        .clk  (clk),
        .rst  (rst),
        .clr  (walk_clr),
        .adv  (walk_adv),
        .idx  (walk_idx),
        .last (walk_last)
    );

    ckrec_scrub_path u_path (
        .rd_code    (rf_rdata),
        .dec        (dec),
        .fixed_code (fixed_code)
    );

    always_comb begin
        in_scrub  = (st == S_SCRUB);
        in_verify = (st == S_VERIFY);
        bad_word  = dec.ce || dec.ue;
        walk_clr  = !(in_scrub || in_verify);
        walk_adv  = (in_scrub && !dec.ue) || (in_verify && !bad_word);
    end

    always_comb begin
        nxt = st;
        case (st)
            S_IDLE:    if (err_now) nxt = S_FREEZE;
            S_FREEZE:  nxt = S_DRAIN;
            S_DRAIN:   if (drain_done) nxt = S_ARST;
                       else if (expired) nxt = S_STOP;
            S_ARST:    nxt = S_AWAIT;
            S_AWAIT:   if (arr_done) nxt = S_SCRUB;
                       else if (expired) nxt = S_STOP;
            S_SCRUB:   if (dec.ue) nxt = S_STOP;
                       else if (walk_last) nxt = S_VERIFY;
            S_VERIFY:  if (bad_word) nxt = S_STOP;
                       else if (walk_last) nxt = S_RESTART;
            S_RESTART: nxt = err_now ? S_STOP : S_WATCH;
            S_WATCH:   if (err_now) nxt = S_STOP;
                       else if (instr_done) nxt = S_IDLE;
            S_STOP:    nxt = S_STOP;
            default:   nxt = S_STOP;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) st <= S_IDLE;
        else     st <= nxt;
    end

    always_comb begin
        ckpt_freeze = (st == S_FREEZE) || (st == S_DRAIN) || (st == S_ARST) ||
                      (st == S_AWAIT) || in_scrub || in_verify || (st == S_STOP);
        busy        = (st != S_IDLE) && (st != S_STOP);
        drain_req   = (st == S_DRAIN);
        arr_reset   = (st == S_ARST);
        rf_addr     = walk_idx;
        rf_we       = in_scrub && !dec.ue;
        rf_wdata    = fixed_code;
        sh_we       = rf_we;
        sh_addr     = walk_idx;
        sh_wdata    = dec.data;
        restart_irq = (st == S_RESTART);
        log_irq     = (st == S_RESTART);
        check_stop  = (st == S_STOP);
    end

endmodule

// File: rtl/ckrec_checker.sv
module ckrec_checker #(
    parameter int AW = 4
) (
    input logic          clk,
    input logic          rst,
    input logic          dup_valid,
    input logic [31:0]   dup_res_a,
    input logic [31:0]   dup_res_b,
    input logic          err_det,
    input logic          busy,
    input logic          ckpt_freeze,
    input logic          drain_req,
    input logic          drain_done,
    input logic          arr_reset,
    input logic          rf_we,
    input logic [AW-1:0] rf_addr,
    input logic          sh_we,
    input logic [AW-1:0] sh_addr,
    input logic          restart_irq,
    input logic          log_irq,
    input logic          check_stop
);

    p_start_r2: assert property (@(posedge clk) disable iff (rst)
        (!busy && !check_stop && ((dup_valid && dup_res_a != dup_res_b) || err_det))
        |=> (busy && ckpt_freeze));

    p_arr_after_drain_r3: assert property (@(posedge clk) disable iff (rst)
        arr_reset |-> $past(drain_req && drain_done));

    p_arr_single_r3: assert property (@(posedge clk) disable iff (rst)
        arr_reset |=> !arr_reset);

    p_shadow_pair_r5: assert property (@(posedge clk) disable iff (rst)
        rf_we |-> (sh_we && sh_addr == rf_addr));

    p_stop_quiet_r6: assert property (@(posedge clk) disable iff (rst)
        check_stop |-> (!rf_we && !busy && !restart_irq && ckpt_freeze));

    p_irq_pair_r8: assert property (@(posedge clk) disable iff (rst)
        restart_irq |-> (log_irq && !ckpt_freeze && busy));

    p_irq_pulse_r8: assert property (@(posedge clk) disable iff (rst)
        restart_irq |=> !restart_irq);

    p_stop_sticky_r10: assert property (@(posedge clk) disable iff (rst)
        check_stop |=> check_stop);

endmodule

bind ckpt_recovery_seq ckrec_checker #(.AW(AW)) i_ckrec_checker (
    .clk         (clk),
    .rst         (rst),
    .dup_valid   (dup_valid),
    .dup_res_a   (dup_res_a),
    .dup_res_b   (dup_res_b),
    .err_det     (err_det),
    .busy        (busy),
    .ckpt_freeze (ckpt_freeze),
    .drain_req   (drain_req),
    .drain_done  (drain_done),
    .arr_reset   (arr_reset),
    .rf_we       (rf_we),
    .rf_addr     (rf_addr),
    .sh_we       (sh_we),
    .sh_addr     (sh_addr),
    .restart_irq (restart_irq),
    .log_irq     (log_irq),
    .check_stop  (check_stop)
);

// File: tb/test_ckpt_recovery_seq.sv
module test_ckpt_recovery_seq;

    localparam int NREG = 16;
    localparam int TMO  = 8;
    localparam int AW   = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic dup_valid = 1'b0;
    logic [31:0] dup_res_a = '0, dup_res_b = '0;
    logic err_det = 1'b0, instr_done = 1'b0;
    logic drain_done = 1'b0, arr_done = 1'b0;
    logic ckpt_freeze, busy, drain_req, arr_reset, rf_we, sh_we;
    logic restart_irq, log_irq, check_stop;
    logic [AW-1:0] rf_addr, sh_addr;
    logic [38:0] rf_rdata, rf_wdata;
    logic [31:0] sh_wdata;

    logic [38:0] mem    [NREG];
    logic [38:0] stuck  [NREG];
    logic [38:0] sval   [NREG];
    logic [31:0] shadow [NREG];
    logic        ld_en = 1'b0;
    logic [AW-1:0] ld_addr = '0;
    logic [38:0] ld_val = '0, ld_stuck = '0;
    logic        mon_clr = 1'b0;
    int          wr_cnt = 0, wr_next = 0, wr_bad = 0;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    ckpt_recovery_seq #(.NREG(NREG), .TIMEOUT(TMO)) i_ckpt_recovery_seq (
        .clk(clk), .rst(rst), .dup_valid(dup_valid), .dup_res_a(dup_res_a),
        .dup_res_b(dup_res_b), .err_det(err_det), .instr_done(instr_done),
        .ckpt_freeze(ckpt_freeze), .busy(busy), .drain_req(drain_req),
        .drain_done(drain_done), .arr_reset(arr_reset), .arr_done(arr_done),
        .rf_addr(rf_addr), .rf_rdata(rf_rdata), .rf_we(rf_we), .rf_wdata(rf_wdata),
        .sh_we(sh_we), .sh_addr(sh_addr), .sh_wdata(sh_wdata),
        .restart_irq(restart_irq), .log_irq(log_irq), .check_stop(check_stop)
    );

    assign rf_rdata = mem[rf_addr];

    always @(posedge clk) begin
        if (ld_en) begin
            mem[ld_addr]   <= ld_val;
            stuck[ld_addr] <= ld_stuck;
            sval[ld_addr]  <= ld_val;
        end else if (rf_we) begin
            mem[rf_addr] <= (rf_wdata & ~stuck[rf_addr]) | (sval[rf_addr] & stuck[rf_addr]);
        end
        if (sh_we) shadow[sh_addr] <= sh_wdata;
        if (mon_clr) begin
            wr_cnt <= 0; wr_next <= 0; wr_bad <= 0;
        end else if (rf_we) begin
            wr_cnt  <= wr_cnt + 1;
            wr_next <= wr_next + 1;
            if (int'(rf_addr) != wr_next) wr_bad <= wr_bad + 1;
        end
    end

    function automatic logic [31:0] orig(input int i);
        return 32'h5A00_0000 ^ (i * 32'h0103_0507);
    endfunction

    // Code layout as stated in R5
    function automatic logic [38:0] tb_enc(input logic [31:0] d);
        logic [38:0] w;
        int k;
        w = '0; k = 0;
        for (int pos = 1; pos <= 38; pos++)
            if ((pos & (pos - 1)) != 0) begin w[pos-1] = d[k]; k++; end
        for (int b = 1; b <= 32; b = b * 2) begin
            logic x;
            x = 1'b0;
            for (int pos = 1; pos <= 38; pos++) if ((pos & b) != 0) x ^= w[pos-1];
            w[b-1] = x;
        end
        w[38] = ^w[37:0];
        return w;
    endfunction

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (3) step();
        rst = 1'b0;
    endtask

    task automatic load_word(input int i, input logic [38:0] mask, input logic [38:0] stk);
        ld_en = 1'b1; ld_addr = AW'(i); ld_val = tb_enc(orig(i)) ^ mask; ld_stuck = stk;
        step();
        ld_en = 1'b0;
    endtask

    task automatic load_clean();
        for (int i = 0; i < NREG; i++) load_word(i, '0, '0);
    endtask

    task automatic prologue(input int dl, input int al, input bit use_err, input bit poke);
        mon_clr = 1'b1;
        if (use_err) err_det = 1'b1;
        else begin dup_valid = 1'b1; dup_res_a = 32'h1234; dup_res_b = 32'h1235; end
        step();
        err_det = 1'b0; dup_valid = 1'b0; mon_clr = 1'b0;
        chk("R2 busy,freeze,drain_req after trigger", {busy, ckpt_freeze, drain_req}, 3'b110);
        step();
        chk("R3 drain_req raised", drain_req, 1);
        for (int i = 0; i < dl - 1; i++) begin
            if (poke && i == 0) err_det = 1'b1;
            step();
            err_det = 1'b0;
            if (poke && i == 0) chk("R11 error in drain ignored", {drain_req, arr_reset, busy}, 3'b101);
        end
        drain_done = 1'b1;
        step();
        drain_done = 1'b0;
        chk("R3 arr_reset pulse after drain", {arr_reset, drain_req}, 2'b10);
        step();
        chk("R3 arr_reset single cycle", arr_reset, 0);
        repeat (al - 1) step();
        arr_done = 1'b1;
        step();
        arr_done = 1'b0;
    endtask

    task automatic wait_end(output bit got_restart);
        got_restart = 0;
        for (int i = 0; i < 4 * NREG && !restart_irq && !check_stop; i++) step();
        got_restart = restart_irq;
    endtask

    task automatic t_reset_state();
        do_reset();
        chk("R1 idle outputs", {busy, check_stop, ckpt_freeze, drain_req, arr_reset,
                               rf_we, sh_we, restart_irq, log_irq}, 0);
    endtask

    task automatic t_no_trigger();
        dup_valid = 1'b0; dup_res_a = 32'h1; dup_res_b = 32'h2;
        step();
        dup_valid = 1'b1; dup_res_a = 32'h77; dup_res_b = 32'h77;
        step();
        dup_valid = 1'b0;
        step();
        chk("R2 no start on invalid or equal", {busy, ckpt_freeze}, 2'b00);
    endtask

    task automatic t_full_recovery();
        bit got;
        int bad;
        load_clean();
        load_word(3, 39'h1 << 10, '0);
        load_word(7, 39'h1 << 38, '0);
        load_word(12, 39'h1, '0);
        prologue(3, 2, 0, 1);
        chk("R5 first write at index 0", {rf_we, 4'(rf_addr)}, {1'b1, 4'd0});
        wait_end(got);
        chk("R8 restart/log/freeze/busy", {restart_irq, log_irq, ckpt_freeze, busy}, 4'b1101);
        step();
        chk("R8 restart single cycle", {restart_irq, log_irq, busy}, 3'b001);
        chk("R5 write count", wr_cnt, NREG);
        chk("R5 write order", wr_bad, 0);
        bad = 0;
        for (int i = 0; i < NREG; i++)
            if (mem[i] !== tb_enc(orig(i)) || shadow[i] !== orig(i)) bad++;
        chk("R5 array and shadow corrected", bad, 0);
        instr_done = 1'b1;
        step();
        instr_done = 1'b0;
        chk("R9 instr_done returns idle", {busy, check_stop}, 2'b00);
    endtask

    task automatic t_watch_both();
        bit got;
        prologue(1, 1, 1, 0);
        wait_end(got);
        chk("R8 restart reached again", got, 1);
        step();
        err_det = 1'b1; instr_done = 1'b1;
        step();
        err_det = 1'b0; instr_done = 1'b0;
        chk("R9 error with instr_done same cycle", {check_stop, busy}, 2'b10);
    endtask

    task automatic t_watch_err();
        bit got;
        do_reset();
        prologue(2, 1, 0, 0);
        wait_end(got);
        step();
        dup_valid = 1'b1; dup_res_a = 32'h5; dup_res_b = 32'h6;
        step();
        dup_valid = 1'b0;
        chk("R9 mismatch after restart", check_stop, 1);
        repeat (5) step();
        chk("R10 check_stop sticky", {check_stop, busy, ckpt_freeze}, 3'b101);
    endtask

    task automatic t_uncorrectable();
        bit got;
        do_reset();
        load_clean();
        load_word(5, (39'h1 << 2) | (39'h1 << 6), '0);
        prologue(1, 1, 0, 0);
        wait_end(got);
        chk("R6 check_stop on double error", {check_stop, got}, 2'b10);
        chk("R6 writes stop below bad word", wr_cnt, 5);
        err_det = 1'b1;
        step();
        err_det = 1'b0;
        repeat (3) step();
        chk("R10 errors ignored in check-stop", {check_stop, busy, ckpt_freeze, drain_req}, 4'b1010);
    endtask

    task automatic t_verify_fail();
        bit got;
        do_reset();
        load_clean();
        load_word(9, 39'h1 << 12, 39'h1 << 12);
        prologue(1, 1, 0, 0);
        wait_end(got);
        chk("R7 solid error stops in confirm pass", {check_stop, got}, 2'b10);
        chk("R7 correction pass completed", wr_cnt, NREG);
    endtask

    task automatic t_drain_timeout();
        do_reset();
        load_clean();
        err_det = 1'b1;
        step();
        err_det = 1'b0;
        step();
        chk("R4 drain wait begins", drain_req, 1);
        repeat (TMO - 1) step();
        chk("R4 still waiting at last cycle", {drain_req, check_stop}, 2'b10);
        step();
        chk("R4 drain timeout check-stop", {check_stop, drain_req}, 2'b10);
    endtask

    task automatic t_arr_boundary();
        do_reset();
        prologue(1, TMO, 0, 0);
        chk("R4 arr_done at last allowed cycle", {rf_we, check_stop}, 2'b10);
        do_reset();
        prologue(1, TMO + 1, 0, 0);
        chk("R4 arr_done one cycle late", {check_stop, rf_we}, 2'b10);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < NREG; i++) begin
            mem[i] = '0; stuck[i] = '0; sval[i] = '0; shadow[i] = '0;
        end
        t_reset_state();
        t_no_trigger();
        t_full_recovery();
        t_watch_both();
        t_watch_err();
        t_uncorrectable();
        t_verify_fail();
        t_drain_timeout();
        t_arr_boundary();
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule